// File: doc/BRIEF.md
# Double-Buffered Serial DAC Word Receiver

This block takes serial words meant for a 12-bit digital-to-analog converter and keeps the code that the converter currently shows. A host drives four slow lines: an active-low frame sync, a serial clock, a serial data line and an active-low load strobe. The block samples all four with its own faster system clock. A received word first goes into an input latch, which has no effect on the converter.

The word moves into the DAC latch in one of two ways. The first is a falling edge of the load strobe while no frame is in progress. The second is the end of the frame, if the strobe is low at that moment. This lets a timer update several converters at the same instant. It also lets a system that holds the strobe low get an update with every word. Each time the DAC latch is loaded, the block raises a one-cycle update pulse next to the new code.

Top module: `dacp_dac_port`

## Requirements
- R1: After the synchronized frame sync falls, the block captures the synchronized data line on each falling serial-clock edge while the frame sync stays low, up to 16 edges. The 16th edge completes the frame.
- R2: Of the 16 captured bits, the first four are discarded. The last 12 form the code, and the first of those 12 is the most significant bit (bit 11).
- R3: A completed frame loads only the input latch. `dac_code_o` changes only when the DAC latch is loaded.
- R4: A falling edge of the load strobe while no frame is in progress copies the input latch into the DAC latch.
- R5: If the load strobe is low when the 16th edge is taken, the new word goes straight into the DAC latch as well as the input latch.
- R6: A falling edge of the load strobe during a frame loads nothing at that edge. If the strobe is still low at the 16th edge, the word is loaded then. If the strobe has gone high again by then, nothing is loaded for that frame.
- R7: After a completed frame, serial-clock edges are ignored until the frame sync has been high. Only a later falling edge of the frame sync opens a new frame.
- R8: If the frame sync rises before the 16th edge, the partial word is discarded. The input latch keeps its previous value.
- R9: `dac_update_o` is high for exactly one system-clock cycle for each load of the DAC latch, and that is the cycle in which the new code first appears.
- R10: Reset clears both latches to zero and holds `dac_update_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_n_i | input | 1 | Frame sync, active low, asynchronous |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB of the code first after 4 pad bits |
| load_n_i | input | 1 | Load strobe, active low, asynchronous |
| dac_code_o | output | 12 | DAC latch contents driving the converter |
| dac_update_o | output | 1 | One-cycle pulse when the DAC latch is loaded |

## Verification
The bench uses the default parameters: 16-bit frames, 4 pad bits and two synchronizer stages. With 12 data bits, the pad bits can be filled with ones to show that they are dropped. The extreme codes 0x800 and 0x7FF can be sent. The serial clock runs at one eighth of the system clock, so a strobe edge can be placed before a frame, inside it, or held across its last bit. The bench also aborts a frame halfway and keeps the frame sync low after a full word, which covers the discard and re-arm rules.

// File: rtl/dacp_pkg.sv
package dacp_pkg;

  // Receiver states for the serial frame engine
  typedef enum logic [1:0] {
    FS_WAIT_HIGH = 2'd0,   // word done or after reset: frame sync must be seen high
    FS_ARMED     = 2'd1,   // ready for a frame sync falling edge
    FS_SHIFT     = 2'd2    // frame in progress
  } fs_state_t;

  // Bit positions of the synchronized input vector
  localparam int IDX_FS  = 0;
  localparam int IDX_SCK = 1;
  localparam int IDX_SD  = 2;
  localparam int IDX_LD  = 3;
  localparam int NUM_ASYNC = 4;

endpackage

// File: rtl/dacp_sync.sv
module dacp_sync #(
  parameter int          WIDTH     = 1,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] fall_o,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RESET_VAL;
          else        stage_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RESET_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  // One more sample for edge comparison
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_VAL;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign fall_o = prev_q & ~stage_q[STAGES-1];
  assign rise_o = ~prev_q & stage_q[STAGES-1];

endmodule

// File: rtl/dacp_frame_rx.sv
module dacp_frame_rx
  import dacp_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fs_lvl_i,     // synchronized frame sync level
  input  logic                 fs_fall_i,    // frame sync falling edge
  input  logic                 sck_fall_i,   // serial clock falling edge
  input  logic                 sdat_i,       // synchronized data bit
  output logic                 busy_o,       // frame in progress
  output logic                 done_o,       // one-cycle: full word captured
  output logic [DATA_BITS-1:0] word_o        // last complete word
);

  localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  fs_state_t            state_q, state_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [DATA_BITS-1:0] shreg_q, shreg_n;
  logic [DATA_BITS-1:0] word_q, word_n;
  logic                 done_q, done_n;
  logic                 shift_en;

  // Next-state logic
  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    shreg_n  = shreg_q;
    word_n   = word_q;
    done_n   = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      FS_WAIT_HIGH: begin
        if (fs_lvl_i) state_n = FS_ARMED;
      end
      FS_ARMED: begin
        if (fs_fall_i) begin
          state_n = FS_SHIFT;
          cnt_n   = '0;
        end
      end
      FS_SHIFT: begin
        if (fs_lvl_i) begin
          // frame sync went high early: drop the partial word
          state_n = FS_ARMED;
        end else if (sck_fall_i) begin
          shift_en = 1'b1;
          shreg_n  = {shreg_q[DATA_BITS-2:0], sdat_i};
          if (cnt_q == LAST_IDX) begin
            done_n  = 1'b1;
            word_n  = shreg_n;
            state_n = FS_WAIT_HIGH;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: state_n = FS_WAIT_HIGH;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_WAIT_HIGH;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_q <= '0;
    else if (shift_en) shreg_q <= shreg_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (done_n) word_q <= word_n;
  end

  assign busy_o = (state_q == FS_SHIFT);
  assign done_o = done_q;
  assign word_o = word_q;

endmodule

// File: rtl/dacp_load_ctrl.sv
module dacp_load_ctrl #(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] word_i,
  input  logic                 busy_i,
  input  logic                 ld_lvl_i,    // synchronized strobe level (low = asserted)
  input  logic                 ld_fall_i,   // strobe falling edge
  output logic [DATA_BITS-1:0] dac_o,
  output logic                 upd_o
);

  logic [DATA_BITS-1:0] in_q, in_n;
  logic [DATA_BITS-1:0] dac_q, dac_n;
  logic                 upd_q, upd_n;
  logic                 in_en, dac_en;

  always_comb begin
    in_n   = in_q;
    dac_n  = dac_q;
    upd_n  = 1'b0;
    in_en  = 1'b0;
    dac_en = 1'b0;
    if (done_i) begin
      in_en = 1'b1;
      in_n  = word_i;
      if (!ld_lvl_i) begin
        // strobe low at end of word: load straight through
        dac_en = 1'b1;
        dac_n  = word_i;
        upd_n  = 1'b1;
      end
    end else if (ld_fall_i && !busy_i) begin
      dac_en = 1'b1;
      dac_n  = in_q;
      upd_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_q <= '0;
    else if (in_en) in_q <= in_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_q <= '0;
    else if (dac_en) dac_q <= dac_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_n;
  end

  assign dac_o = dac_q;
  assign upd_o = upd_q;

endmodule

// File: rtl/dacp_dac_port.sv
module dacp_dac_port
  import dacp_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int PAD_BITS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_BITS  = FRAME_BITS - PAD_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fsync_n_i,
  input  logic                 sclk_i,
  input  logic                 sdata_i,
  input  logic                 load_n_i,
  output logic [DATA_BITS-1:0] dac_code_o,
  output logic                 dac_update_o
);

  logic [NUM_ASYNC-1:0] raw_in, s_lvl, s_fall, s_rise;
  logic                 frm_busy, frm_done;
  logic [DATA_BITS-1:0] frm_word;
  logic                 ld_lvl, ld_fall;

  always_comb begin
    raw_in          = '0;
    raw_in[IDX_FS]  = fsync_n_i;
    raw_in[IDX_SCK] = sclk_i;
    raw_in[IDX_SD]  = sdata_i;
    raw_in[IDX_LD]  = load_n_i;
  end

  dacp_sync #(
    .WIDTH     (NUM_ASYNC),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL ('1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (s_lvl),
    .fall_o  (s_fall),
    .rise_o  (s_rise)
  );

  assign ld_lvl  = s_lvl[IDX_LD];
  assign ld_fall = s_fall[IDX_LD];

  dacp_frame_rx #(
    .FRAME_BITS (FRAME_BITS),
    .DATA_BITS  (DATA_BITS)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_lvl_i   (s_lvl[IDX_FS]),
    .fs_fall_i  (s_fall[IDX_FS]),
    .sck_fall_i (s_fall[IDX_SCK]),
    .sdat_i     (s_lvl[IDX_SD]),
    .busy_o     (frm_busy),
    .done_o     (frm_done),
    .word_o     (frm_word)
  );

  dacp_load_ctrl #(
    .DATA_BITS (DATA_BITS)
  ) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (frm_done),
    .word_i    (frm_word),
    .busy_i    (frm_busy),
    .ld_lvl_i  (ld_lvl),
    .ld_fall_i (ld_fall),
    .dac_o     (dac_code_o),
    .upd_o     (dac_update_o)
  );

endmodule

// File: rtl/dacp_dac_port_chk.sv
module dacp_dac_port_chk #(
  parameter int DATA_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DATA_BITS-1:0] dac_code,
  input logic                 dac_update,
  input logic                 frame_done,
  input logic                 frame_busy,
  input logic                 load_lvl,
  input logic                 load_fall
);

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_update |=> !dac_update); // R9

  AST_CODE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> dac_update); // R3

  AST_FALL_IN_FRAME_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && load_fall) |=> !dac_update); // R6

  AST_END_LOW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !load_lvl) |=> dac_update); // R5

  AST_END_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && load_lvl) |=> !dac_update); // R3

  AST_IDLE_FALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && !frame_busy) |=> dac_update); // R4

endmodule

bind dacp_dac_port dacp_dac_port_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dac_code   (dac_code_o),
  .dac_update (dac_update_o),
  .frame_done (frm_done),
  .frame_busy (frm_busy),
  .load_lvl   (ld_lvl),
  .load_fall  (ld_fall)
);

// File: tb/dacp_dac_port_bench.sv
module dacp_dac_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int FRAME_BITS = 16;
  localparam int DATA_BITS  = 12;
  localparam int WDOG_LIMIT = 100000;

  logic                 clk;
  logic                 rst_n;
  logic                 fsync_n, sclk, sdata, load_n;
  logic [DATA_BITS-1:0] dac_code;
  logic                 dac_update;

  int checks = 0;
  int fails  = 0;
  logic [DATA_BITS-1:0] exp_q[$];
  string                tag_q[$];
  logic [DATA_BITS-1:0] in_model;
  bit                   in_frame;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  dacp_dac_port u_dacp_dac_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .fsync_n_i    (fsync_n),
    .sclk_i       (sclk),
    .sdata_i      (sdata),
    .load_n_i     (load_n),
    .dac_code_o   (dac_code),
    .dac_update_o (dac_update)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_load(input logic [DATA_BITS-1:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // Scoreboard monitor: every update pulse must match the next expected code
  always @(negedge clk) begin
    if (rst_n && dac_update) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R9: actual 0x%0h expected no update", dac_code);
      end else begin
        logic [DATA_BITS-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dac_code === e, t, dac_code, e);
      end
    end
  end

  task automatic set_load(input logic v, input string req);
    if (!v && load_n && !in_frame) expect_load(in_model, req);
    load_n = v;
    tick(8);
  endtask

  task automatic pulse_load(input string req);
    set_load(1'b0, req);
    set_load(1'b1, req);
  endtask

  // Send nbits of w (MSB first); strobe may fall/rise at given bit indices
  task automatic send_frame(input logic [FRAME_BITS-1:0] w, input int nbits,
                            input int fall_at, input int rise_at,
                            input bit keep_low, input string req);
    in_frame = 1'b1;
    fsync_n  = 1'b0;
    tick(HALF_SCK);
    for (int i = 0; i < nbits; i++) begin
      if (i == fall_at) load_n = 1'b0;
      if (i == rise_at) load_n = 1'b1;
      sdata = w[FRAME_BITS-1-i];
      if (i == FRAME_BITS-1 && !load_n) expect_load(w[DATA_BITS-1:0], req);
      tick(HALF_SCK);
      sclk = 1'b0;
      tick(HALF_SCK);
      sclk = 1'b1;
    end
    if (nbits == FRAME_BITS) in_model = w[DATA_BITS-1:0];
    tick(8);
    if (!keep_low) begin
      fsync_n = 1'b1;
      tick(8);
    end
    in_frame = 1'b0;
  endtask

  // Clock bits with frame sync left as it is
  task automatic clock_bits(input logic [FRAME_BITS-1:0] w);
    for (int i = 0; i < FRAME_BITS; i++) begin
      sdata = w[FRAME_BITS-1-i];
      tick(HALF_SCK);
      sclk = 1'b0;
      tick(HALF_SCK);
      sclk = 1'b1;
    end
    tick(8);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG_LIMIT);
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    fsync_n  = 1'b1;
    sclk     = 1'b1;
    sdata    = 1'b0;
    load_n   = 1'b1;
    in_model = '0;
    in_frame = 1'b0;
    tick(5);
    check(dac_code === '0, "R10", dac_code, 0);
    check(dac_update === 1'b0, "R10", dac_update, 0);
    rst_n = 1'b1;
    tick(5);
    check(dac_code === '0, "R10", dac_code, 0);

    // R3: word with strobe high stays in the input latch
    send_frame(16'hFABC, FRAME_BITS, -1, -1, 1'b0, "R3");
    check(dac_code === '0, "R3", dac_code, 0);
    // R4 / R2: strobe edge moves it; pad bits (all ones) dropped
    pulse_load("R4");
    check(dac_code === 12'hABC, "R2", dac_code, 12'hABC);

    // R5: strobe held low, load at the 16th edge; extreme codes (R1)
    set_load(1'b0, "R4");
    send_frame(16'h3800, FRAME_BITS, -1, -1, 1'b0, "R5");
    check(dac_code === 12'h800, "R1", dac_code, 12'h800);
    send_frame(16'h07FF, FRAME_BITS, -1, -1, 1'b0, "R5");
    check(dac_code === 12'h7FF, "R5", dac_code, 12'h7FF);
    set_load(1'b1, "R5");

    // R6: strobe falls mid-frame and stays low
    send_frame(16'h1555, FRAME_BITS, 5, -1, 1'b0, "R6");
    check(dac_code === 12'h555, "R6", dac_code, 12'h555);
    set_load(1'b1, "R6");

    // R6: strobe falls and returns high inside the frame
    send_frame(16'h0FED, FRAME_BITS, 3, 9, 1'b0, "R6");
    check(dac_code === 12'h555, "R6", dac_code, 12'h555);
    pulse_load("R6");
    check(dac_code === 12'hFED, "R6", dac_code, 12'hFED);

    // R8: partial frame discarded
    send_frame(16'h0111, FRAME_BITS, -1, -1, 1'b0, "R8");
    send_frame(16'hFFFF, 8, -1, -1, 1'b0, "R8");
    check(dac_code === 12'hFED, "R8", dac_code, 12'hFED);
    pulse_load("R8");
    check(dac_code === 12'h111, "R8", dac_code, 12'h111);

    // R7: frame sync kept low after a word, further bits ignored
    set_load(1'b0, "R7");
    send_frame(16'h0AAA, FRAME_BITS, -1, -1, 1'b1, "R7");
    clock_bits(16'h0CCC);
    fsync_n = 1'b1;
    tick(10);
    check(dac_code === 12'hAAA, "R7", dac_code, 12'hAAA);
    set_load(1'b1, "R7");

    // R1: a new frame is taken after frame sync returned high
    send_frame(16'h0246, FRAME_BITS, -1, -1, 1'b0, "R1");
    pulse_load("R1");
    check(dac_code === 12'h246, "R1", dac_code, 12'h246);

    tick(20);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule